// File: doc/BRIEF.md
# Processor Processing-State Controller

This block keeps the top-level operating condition of a small CPU core. The core is always in one of four conditions: running instructions normally, handling an exception, stopped quietly, or halted for good. Single-cycle strobes stand in for instruction decode and the bus interface. They report a stop instruction, an exception request, a pending interrupt, an access error, an address error and the end of exception handling. From these strobes the controller moves between the four conditions.

A synchronous reset sends the core into exception handling, where it fetches its start vector. The end-of-exception strobe then lets it run normally. A fault that arrives while an exception is being handled cannot be recovered, so the core halts and stays halted until the next reset. A stop instruction parks the core with the bus idle, and only an interrupt or a reset wakes it. The outputs give the current condition, a bus-enable, a halted flag and a one-cycle request to save the core context when an exception starts in the normal way.

Top module: `proc_state_ctrl`

## Requirements
- R1: The condition code on `state_o` is 0 normal, 1 exception, 2 stopped, 3 halted. When `rst` is high at a rising clock edge, `state_o` is 1 after that edge and `save_ctx` is 0. Reset wins over every other input in the same cycle.
- R2: In the normal condition, any of `exc_req`, `access_err`, `address_err` or `irq_pend` moves the core to the exception condition at the next edge. This takes priority over `stop_instr` in the same cycle.
- R3: In the normal condition, `stop_instr` with no exception cause moves the core to the stopped condition.
- R4: In the exception condition, `exc_done` with no fault moves the core to the normal condition.
- R5: In the exception condition, `access_err` or `address_err` moves the core to the halted condition, even if `exc_done` is high in the same cycle.
- R6: In the halted condition every input except `rst` is ignored, and the condition stays halted.
- R7: In the stopped condition, `irq_pend` moves the core to the exception condition. Stop, fault, request and done strobes have no effect there.
- R8: `bus_en` is 0 in the stopped and halted conditions and 1 in the other two. `halted` is 1 only in the halted condition.
- R9: `save_ctx` is 1 for exactly the first cycle of an exception condition that was entered from the normal or stopped condition. It is 0 when the exception follows a reset, and 0 on the cycle a double fault halts the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | An interrupt is pending |
| stop_instr | input | 1 | A stop instruction executed this cycle |
| exc_req | input | 1 | Exception requested (trap, illegal op, etc.) |
| access_err | input | 1 | Bus access error strobe |
| address_err | input | 1 | Address error strobe |
| exc_done | input | 1 | Exception handling finished |
| state_o | output | 2 | Current condition code |
| bus_en | output | 1 | Bus cycles allowed |
| halted | output | 1 | Core is halted |
| save_ctx | output | 1 | Save internal context this cycle |

## Verification
Every output is decoded from a single registered condition, so a wrong transition shows on `state_o`, `bus_en` and `halted` in the cycle right after the edge that took it. A wrong halt or stop is therefore seen within one clock. Missing the double-fault rule shows either as a return to normal, or as a `save_ctx` pulse where none belongs. A wrong priority between simultaneous strobes shows only when those strobes coincide, so the vectors drive such coincidences on purpose.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    localparam int PS_W = 2;

    typedef enum logic [PS_W-1:0] {
        PS_NORMAL  = 2'd0,
        PS_EXCEPT  = 2'd1,
        PS_STOPPED = 2'd2,
        PS_HALTED  = 2'd3
    } pstate_e;

    typedef struct packed {
        logic fault;
        logic irq;
        logic stop;
        logic exreq;
        logic done;
    } ps_evt_t;

    function automatic logic bus_active(pstate_e s);
        return (s == PS_NORMAL) || (s == PS_EXCEPT);
    endfunction

    function automatic logic may_save(pstate_e s);
        return (s == PS_NORMAL) || (s == PS_STOPPED);
    endfunction

endpackage

// File: rtl/ps_event_gather.sv
module ps_event_gather
    import pstate_pkg::*;
(
    input  logic    irq_pend,
    input  logic    stop_instr,
    input  logic    exc_req,
    input  logic    access_err,
    input  logic    address_err,
    input  logic    exc_done,
    output ps_evt_t evt
);
    always_comb begin
        evt.fault = access_err | address_err;
        evt.irq   = irq_pend;
        evt.stop  = stop_instr;
        evt.exreq = exc_req;
        evt.done  = exc_done;
    end
endmodule

// File: rtl/ps_next_state.sv
module ps_next_state
    import pstate_pkg::*;
(
    input  pstate_e cur,
    input  ps_evt_t evt,
    output pstate_e nxt,
    output logic    save_d
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            PS_NORMAL: begin
                if (evt.fault || evt.exreq || evt.irq) nxt = PS_EXCEPT;
                else if (evt.stop)                      nxt = PS_STOPPED;
            end
            PS_EXCEPT: begin
                if (evt.fault)     nxt = PS_HALTED;
                else if (evt.done) nxt = PS_NORMAL;
            end
            PS_STOPPED: begin
                if (evt.irq) nxt = PS_EXCEPT;
            end
            PS_HALTED: nxt = PS_HALTED;
            default:   nxt = PS_HALTED;
        endcase
        save_d = (nxt == PS_EXCEPT) && may_save(cur);
    end
endmodule

// File: rtl/ps_out_decode.sv
module ps_out_decode
    import pstate_pkg::*;
(
    input  pstate_e         cur,
    output logic [PS_W-1:0] state_o,
    output logic            bus_en,
    output logic            halted
);
    always_comb begin
        state_o = cur;
        bus_en  = bus_active(cur);
        halted  = (cur == PS_HALTED);
    end
endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl
    import pstate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_pend,
    input  logic            stop_instr,
    input  logic            exc_req,
    input  logic            access_err,
    input  logic            address_err,
    input  logic            exc_done,
    output logic [PS_W-1:0] state_o,
    output logic            bus_en,
    output logic            halted,
    output logic            save_ctx
);
    pstate_e cur_q;
    pstate_e nxt;
    ps_evt_t evt;
    logic    save_d;

    ps_event_gather u_gather (
        .irq_pend    (irq_pend),
        .stop_instr  (stop_instr),
        .exc_req     (exc_req),
        .access_err  (access_err),
        .address_err (address_err),
        .exc_done    (exc_done),
        .evt         (evt)
    );

    ps_next_state u_next (
        .cur    (cur_q),
        .evt    (evt),
        .nxt    (nxt),
        .save_d (save_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= PS_EXCEPT;
            save_ctx <= 1'b0;
        end else begin
            cur_q    <= nxt;
            save_ctx <= save_d;
        end
    end

    ps_out_decode u_out (
        .cur     (cur_q),
        .state_o (state_o),
        .bus_en  (bus_en),
        .halted  (halted)
    );
endmodule

// File: rtl/ps_state_checker.sv
module ps_state_checker (
    input logic       clk,
    input logic       rst,
    input logic       irq_pend,
    input logic       access_err,
    input logic       address_err,
    input logic [1:0] state_o,
    input logic       bus_en,
    input logic       halted,
    input logic       save_ctx
);
    assert_reset_entry_R1: assert property (@(posedge clk)
        rst |=> (state_o == 2'd1) && !save_ctx);

    assert_double_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1) && (access_err || address_err) |=> (state_o == 2'd3));

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |=> (state_o == 2'd3));

    assert_stop_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) && irq_pend |=> (state_o == 2'd1));

    assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        state_o[1] |-> !bus_en);

    assert_halt_nosave_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> !save_ctx);
endmodule

bind proc_state_ctrl ps_state_checker chk (
    .clk         (clk),
    .rst         (rst),
    .irq_pend    (irq_pend),
    .access_err  (access_err),
    .address_err (address_err),
    .state_o     (state_o),
    .bus_en      (bus_en),
    .halted      (halted),
    .save_ctx    (save_ctx)
);

// File: tb/proc_state_ctrl_test.sv
`timescale 1ns/1ps
module proc_state_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_pend = 0, stop_instr = 0, exc_req = 0;
    logic       access_err = 0, address_err = 0, exc_done = 0;
    logic [1:0] state_o;
    logic       bus_en, halted, save_ctx;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    proc_state_ctrl uut (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .stop_instr(stop_instr),
        .exc_req(exc_req), .access_err(access_err), .address_err(address_err),
        .exc_done(exc_done), .state_o(state_o), .bus_en(bus_en),
        .halted(halted), .save_ctx(save_ctx)
    );

    // bits: [8]irq [7]stop [6]exreq [5]acc [4]addr [3]done [2:1]expected state [0]expected save
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        9'b000001_00_0, // R4 done -> normal
        9'b000000_00_0, // idle stays normal
        9'b001000_01_1, // R2 request -> exception, save
        9'b000001_00_0, // R4
        9'b010000_10_0, // R3 stop
        9'b001110_10_0, // R7 faults/request ignored while stopped
        9'b010001_10_0, // R7 stop/done ignored
        9'b100000_01_1, // R7 irq wakes, R9 save
        9'b000001_00_0, // R4
        9'b010010_01_1, // R2 address error beats stop
        9'b000100_11_0, // R5 double fault halts, R9 no save
        9'b100000_11_0, // R6 irq ignored
        9'b000001_11_0, // R6 done ignored
        9'b011110_11_0, // R6 all ignored
        9'b111111_11_0  // R6 all at once
    };

    task automatic check(input string req, input logic [1:0] exp_st, input logic exp_sv);
        logic exp_bus;
        logic exp_halt;
        exp_bus  = (exp_st == 2'd0) || (exp_st == 2'd1);
        exp_halt = (exp_st == 2'd3);
        total++;
        if (state_o !== exp_st || bus_en !== exp_bus || halted !== exp_halt || save_ctx !== exp_sv) begin
            bad++;
            $display("FAIL %s: state=%0d bus_en=%0b halted=%0b save=%0b expected state=%0d bus_en=%0b halted=%0b save=%0b",
                     req, state_o, bus_en, halted, save_ctx, exp_st, exp_bus, exp_halt, exp_sv);
        end
    endtask

    task automatic step(input logic [5:0] ins);
        @(negedge clk);
        {irq_pend, stop_instr, exc_req, access_err, address_err, exc_done} = ins;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic [5:0] ins);
        @(negedge clk);
        rst = 1'b1;
        {irq_pend, stop_instr, exc_req, access_err, address_err, exc_done} = ins;
        @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    initial begin
        do_reset(6'b0);
        check("R1 reset state", 2'd1, 1'b0);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8:3]);
            check($sformatf("vector %0d (R2-R9 table)", i), VEC[i][2:1], VEC[i][0]);
        end
        // R1: reset leaves halted, and wins over faults in the same cycle
        do_reset(6'b111111);
        check("R1 reset beats faults", 2'd1, 1'b0);
        // R5: fault with done in the same cycle still halts
        step(6'b000101);
        check("R5 fault with done", 2'd3, 1'b0);
        do_reset(6'b0);
        step(6'b000001);
        check("R4 after reset", 2'd0, 1'b0);
        // R2: irq in normal, stop in same cycle
        step(6'b110000);
        check("R2 irq beats stop", 2'd1, 1'b1);
        // R9: pulse lasts one cycle only
        step(6'b000000);
        check("R9 save single cycle", 2'd1, 1'b0);
        step(6'b000001);
        step(6'b000100);
        check("R2 access error", 2'd1, 1'b1);
        step(6'b000001);
        step(6'b010000);
        check("R8 stopped bus quiet", 2'd2, 1'b0);
        do_reset(6'b0);
        check("R1 reset from stopped", 2'd1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule